// File: doc/BRIEF.md
# Packed Halfword Saturating Arithmetic Unit

This unit takes two 64-bit operands and treats each as four independent 16-bit lanes. It applies one of seven lane-wise operations to every lane pair at once: signed-saturating add or subtract, add or subtract that saturates to the unsigned range, unsigned average, and two scaled adds that shift the first lane by 0 to 3 bit positions, left or right, before adding. No carry or borrow crosses a lane boundary.

A datapath issues an opcode, a 2-bit shift amount and the two operands together with a valid strobe. The 64-bit packed result comes back one cycle later, marked by a valid output that follows the input strobe. A parameter can remove the output register, which makes the unit purely combinational.

Top module: `lane_sat_alu`

## Requirements
- R1: Lane k (k = 0..3) of the result depends only on bits [16k+15:16k] of each operand. No carry or borrow crosses a lane boundary.
- R2: Opcode 0 (signed add) and opcode 1 (signed subtract) sign-extend both lanes, compute the exact sum or difference, and clamp it to -32768..32767 (0x8000..0x7FFF).
- R3: Opcode 2 (add) and opcode 3 (subtract) read the first lane as unsigned and the second lane as signed two's complement. The exact result is clamped to 0..65535.
- R4: Opcode 4 (average) forms the 17-bit unsigned sum s of the two lanes. The lane result is (s >> 1) with bit 0 of s ORed into its bit 0.
- R5: Opcode 5 shifts the sign-extended first lane left by shamt (0..3), adds the sign-extended second lane, and clamps the exact result to -32768..32767.
- R6: Opcode 6 shifts the sign-extended first lane right arithmetically by shamt, adds the sign-extended second lane, and clamps to -32768..32767.
- R7: Opcode 7 is unused and gives an all-zero result.
- R8: With the output register present (the default), result and out_valid appear one clock after the inputs are sampled, and out_valid equals in_valid of that earlier cycle. During reset both result and out_valid are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| opcode | input | 3 | Operation select (encoding given in R2 to R7) |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| shamt | input | 2 | Shift amount for the scaled adds |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Packed lane results |

## Verification
The bench aims at the clamp edges: 0x7FFF + 1, 0x8000 - 1, and an unsigned lane at 0xFFFF combined with a negative second lane. A design that wrapped instead of saturating, or that zero-extended the second operand in the unsigned modes, would return the wrapped value or the wrong rail. It also drives the largest shift on values that overflow only after shifting, and a right shift of negative lanes. A narrow internal width or a logical shift would show up there as a wrong sign or a missed clamp. Vectors that mix saturating and non-saturating lanes expose any carry leaking between lanes. Odd-sum averages catch rounding by truncation. Idle gaps between issues check that out_valid tracks the strobe with one cycle of delay.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [2:0] {
        OP_ADD_SS  = 3'd0,
        OP_SUB_SS  = 3'd1,
        OP_ADD_US  = 3'd2,
        OP_SUB_US  = 3'd3,
        OP_AVG     = 3'd4,
        OP_SHL_ADD = 3'd5,
        OP_SHR_ADD = 3'd6,
        OP_NONE    = 3'd7
    } lsa_op_e;
endpackage

// File: rtl/lsa_clamp.sv
// Saturates a wide signed value to OUT_W bits, signed or unsigned range.
module lsa_clamp #(
    parameter int IN_W  = 21,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  wide,
    input  logic             uns_mode,
    output logic [OUT_W-1:0] sat
);
    logic               neg;
    logic [IN_W-OUT_W:0]  hi_s;
    logic [IN_W-OUT_W-1:0] hi_u;
    logic               fits_s;
    logic               fits_u;

    always_comb begin
        neg    = wide[IN_W-1];
        hi_s   = wide[IN_W-1:OUT_W-1];
        hi_u   = wide[IN_W-1:OUT_W];
        fits_s = (hi_s == '0) || (hi_s == '1);
        fits_u = (hi_u == '0);
        if (uns_mode) begin
            if (neg)          sat = '0;
            else if (!fits_u) sat = '1;
            else              sat = wide[OUT_W-1:0];
        end else begin
            if (fits_s)       sat = wide[OUT_W-1:0];
            else if (neg)     sat = {1'b1, {(OUT_W-1){1'b0}}};
            else              sat = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/lsa_lane.sv
// One lane: exact wide arithmetic followed by a shared clamp.
module lsa_lane
    import lsa_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int SH_W   = 2,
    parameter int EXT_W  = 21
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  lsa_op_e           op,
    input  logic [SH_W-1:0]   sh,
    output logic [LANE_W-1:0] res
);
    logic signed [EXT_W-1:0] sa, sb, za, zb;
    logic signed [EXT_W-1:0] wide;
    logic                    uns;
    logic                    is_avg;
    logic                    op_ok;
    logic [LANE_W-1:0]       sat;
    logic [LANE_W-1:0]       avg;

    always_comb begin
        sa     = {{(EXT_W-LANE_W){a[LANE_W-1]}}, a};
        sb     = {{(EXT_W-LANE_W){b[LANE_W-1]}}, b};
        za     = {{(EXT_W-LANE_W){1'b0}}, a};
        zb     = {{(EXT_W-LANE_W){1'b0}}, b};
        wide   = '0;
        uns    = 1'b0;
        is_avg = 1'b0;
        op_ok  = 1'b1;
        case (op)
            OP_ADD_SS:  wide = sa + sb;
            OP_SUB_SS:  wide = sa - sb;
            OP_ADD_US:  begin wide = za + sb; uns = 1'b1; end
            OP_SUB_US:  begin wide = za - sb; uns = 1'b1; end
            OP_AVG:     begin wide = za + zb; is_avg = 1'b1; end
            OP_SHL_ADD: wide = (sa <<< sh) + sb;
            OP_SHR_ADD: wide = (sa >>> sh) + sb;
            default:    op_ok = 1'b0;
        endcase
    end

    lsa_clamp #(.IN_W(EXT_W), .OUT_W(LANE_W)) u_clamp (
        .wide     (wide),
        .uns_mode (uns),
        .sat      (sat)
    );

    always_comb begin
        avg = wide[LANE_W:1] | {{(LANE_W-1){1'b0}}, wide[0]};
        if (!op_ok)      res = '0;
        else if (is_avg) res = avg;
        else             res = sat;
    end
endmodule

// File: rtl/lane_sat_alu.sv
module lane_sat_alu
    import lsa_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 16,
    parameter int SH_W    = 2,
    parameter int REG_OUT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               opcode,
    input  logic [LANES*LANE_W-1:0]  op_a,
    input  logic [LANES*LANE_W-1:0]  op_b,
    input  logic [SH_W-1:0]          shamt,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  result
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int EXT_W  = LANE_W + (1 << SH_W) + 1;

    lsa_op_e           op_sel;
    logic [DATA_W-1:0] comb_res;

    assign op_sel = lsa_op_e'(opcode);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lsa_lane #(.LANE_W(LANE_W), .SH_W(SH_W), .EXT_W(EXT_W)) u_lane (
            .a   (op_a[i*LANE_W +: LANE_W]),
            .b   (op_b[i*LANE_W +: LANE_W]),
            .op  (op_sel),
            .sh  (shamt),
            .res (comb_res[i*LANE_W +: LANE_W])
        );
    end

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    if (REG_OUT != 0) begin : g_reg
        stage_t stage_d, stage_q;

        always_comb begin
            stage_d     = stage_q;
            stage_d.vld = in_valid;
            stage_d.res = comb_res;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end

        assign out_valid = stage_q.vld;
        assign result    = stage_q.res;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = comb_res;
    end
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int LANES   = 4,
    parameter int LANE_W  = 16,
    parameter int REG_OUT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              opcode,
    input  logic [LANES*LANE_W-1:0] op_a,
    input  logic [LANES*LANE_W-1:0] op_b,
    input  logic                    out_valid,
    input  logic [LANES*LANE_W-1:0] result
);
    logic                    seen_ok;
    logic                    seen_vld;
    logic [2:0]              seen_op;
    logic [LANES*LANE_W-1:0] seen_a;
    logic [LANES*LANE_W-1:0] seen_b;

    if (REG_OUT != 0) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_ok  <= 1'b0;
                seen_vld <= 1'b0;
                seen_op  <= '0;
                seen_a   <= '0;
                seen_b   <= '0;
            end else begin
                seen_ok  <= 1'b1;
                seen_vld <= in_valid;
                seen_op  <= opcode;
                seen_a   <= op_a;
                seen_b   <= op_b;
            end
        end
    end else begin : g_now
        assign seen_ok  = 1'b1;
        assign seen_vld = in_valid;
        assign seen_op  = opcode;
        assign seen_a   = op_a;
        assign seen_b   = op_b;
    end

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        seen_ok |-> (out_valid == seen_vld)); // R8

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_ok && out_valid && seen_op == 3'd7) |-> (result == '0)); // R7

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        logic [LANE_W-1:0] la, lb, lr;
        assign la = seen_a[k*LANE_W +: LANE_W];
        assign lb = seen_b[k*LANE_W +: LANE_W];
        assign lr = result[k*LANE_W +: LANE_W];

        AST_SS_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_ok && out_valid && seen_op == 3'd0 && !la[LANE_W-1] && !lb[LANE_W-1])
            |-> !lr[LANE_W-1]); // R2

        AST_US_ADD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_ok && out_valid && seen_op == 3'd2 && !lb[LANE_W-1])
            |-> (lr >= la)); // R3

        AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_ok && out_valid && seen_op == 3'd4)
            |-> ((lr >= ((la < lb) ? la : lb)) && (lr <= ((la < lb) ? lb : la)))); // R4
    end
endmodule

bind lane_sat_alu lsa_checker #(
    .LANES   (LANES),
    .LANE_W  (LANE_W),
    .REG_OUT (REG_OUT)
) u_lsa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_sat_alu_bench.sv
`timescale 1ns/1ps
module lane_sat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  shamt = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    lane_sat_alu u_lane_sat_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .shamt(shamt),
        .out_valid(out_valid), .result(result)
    );

    function automatic int ssat(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int usat(input int v);
        if (v > 65535) return 65535;
        if (v < 0)     return 0;
        return v;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [2:0] op, input logic [1:0] sh);
        logic [63:0] o;
        o = '0;
        for (int i = 0; i < 4; i++) begin
            int sa, sbv, ua, ub, r, s;
            sa  = $signed(a[16*i +: 16]);
            sbv = $signed(b[16*i +: 16]);
            ua  = int'(a[16*i +: 16]);
            ub  = int'(b[16*i +: 16]);
            case (op)
                3'd0: r = ssat(sa + sbv);
                3'd1: r = ssat(sa - sbv);
                3'd2: r = usat(ua + sbv);
                3'd3: r = usat(ua - sbv);
                3'd4: begin s = ua + ub; r = (s >> 1) | (s & 1); end
                3'd5: r = ssat(sa * (1 << sh) + sbv);
                3'd6: r = ssat((sa >>> sh) + sbv);
                default: r = 0;
            endcase
            o[16*i +: 16] = r[15:0];
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] a, input logic [63:0] b,
                        input logic [2:0] op, input logic [1:0] sh, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a; op_b = b; opcode = op; shamt = sh;
        it.exp = model(a, b, op, sh);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = 64'hDEAD_BEEF_0BAD_F00D; opcode = 3'd0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result is flagged valid.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected out_valid", result, 64'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(result === 64'h0 && out_valid === 1'b0, "R8 reset state", result, 64'h0);
        rst_n = 1'b1;
        idle(2);

        // R2 signed clamps, mixed per lane (R1)
        send(64'h7FFF_8000_1234_0005, 64'h0001_FFFF_0100_FFFD, 3'd0, 2'd0, "R2 add_ss R1 lanes");
        send(64'h8000_7FFF_0010_FFFF, 64'h0001_FFFF_0020_0001, 3'd1, 2'd0, "R2 sub_ss");
        // R3 unsigned clamps, b signed
        send(64'hFFFF_0000_8000_0010, 64'h0001_FFFF_7FFF_FFF0, 3'd2, 2'd0, "R3 add_us");
        send(64'h0000_FFF0_0005_8000, 64'h0001_FFF0_0002_7FFF, 3'd3, 2'd0, "R3 sub_us");
        idle(1);
        // R4 average rounding
        send(64'hFFFF_0000_0002_0004, 64'hFFFF_0001_0003_0004, 3'd4, 2'd0, "R4 avg");
        // R5 shift-left add
        send(64'h1000_F000_0003_FFFF, 64'h0000_FFFF_0001_0002, 3'd5, 2'd3, "R5 shl sh3");
        send(64'h7FFF_4000_0001_8000, 64'h0000_0000_0001_0000, 3'd5, 2'd0, "R5 shl sh0");
        send(64'h2000_C000_1111_0100, 64'h0001_FFFF_0000_0002, 3'd5, 2'd1, "R5 shl sh1");
        // R6 shift-right add
        send(64'h8000_FFFF_7FFF_0009, 64'h0010_0000_7FFF_8000, 3'd6, 2'd3, "R6 shr sh3");
        send(64'hFFFF_8000_0003_7FFF, 64'h0000_8000_0000_7FFF, 3'd6, 2'd1, "R6 shr sh1");
        // R7 unused opcode
        send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 3'd7, 2'd2, "R7 unused op");
        idle(3);
        // R1 sweep over all opcodes with pseudo-random data
        for (int n = 0; n < 300; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            send(ra, rb, 3'(n % 8), 2'($urandom % 4), "R1 sweep");
            if (n % 17 == 0) idle(1);
        end
        idle(4);
        check(out_valid === 1'b0, "R8 idle out_valid", {63'h0, out_valid}, 64'h0);
        check(sb_q.size() == 0, "R8 all results returned", 64'(sb_q.size()), 64'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule